// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Sequencer

This block governs how a small processor enters and leaves a low-power stop state. When the processor issues a stop request, the block shuts down the oscillator, the PLL and every derived clock enable. Memory contents are kept because only the clock enables change. The stop state ends when an enabled and qualified interrupt request arrives, or when a hardware reset is applied.

When an interrupt wakes the block, the oscillator and the peripheral clocks come back at once. The CPU and bus clock then follows one of two paths:
- If the clock comes from a stable external source and the PLL is bypassed, the CPU clock resumes immediately.
- Otherwise the block first runs an oscillation-stabilization wait. This wait uses the watchdog's down-counter, which is loaded to all ones and clocked from a wake-specific prescaler tap. The CPU clock resumes when the counter's top bit clears.

One cycle after the CPU clock returns, the block issues a single-cycle accept strobe for the waking interrupt, together with its index.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset is released, the block is running: `osc_en`, `per_clk_en` and `cpu_clk_en` are 1, `pll_en` equals `pll_on`, `wdt_cnt` is 0 and `irq_ack` is 0.
- R2: A `stop_req` sampled while running drives `osc_en`, `pll_en`, `per_clk_en` and `cpu_clk_en` to 0 from the next cycle on. While stopped, `wdt_cnt` holds its value.
- R3: A source wakes the block only when both `irq_req[i]` and `irq_en[i]` are 1. If bit i of `COND_MASK` is 1, `irq_cond[i]` must also be 1; otherwise the source is ignored and the block stays stopped.
- R4: The first qualifying request to arrive performs the wake-up. If several qualify in the same cycle, the lowest index wins. The index reported on `irq_ack_id` is the waking one, even if other requests arrive during stabilization.
- R5: In the cycle after the waking request is sampled, `osc_en` and `per_clk_en` are both 1. `pll_en` is 1 only if `pll_on` is 1.
- R6: With `ext_clk_sel`=1 and `pll_sel`=0, `cpu_clk_en` rises in the same cycle as `osc_en`.
- R7: In every other clock configuration, `wdt_cnt` is loaded with all ones on wake-up. It then decrements once every `16 << wake_div` cycles (`wake_div` 0..3 gives divide by 16, 32, 64 or 128). `cpu_clk_en` rises when bit `CNT_W-1` clears, which is `2^(CNT_W-1) * (16 << wake_div)` cycles after the wake edge, with `wdt_cnt` = `2^(CNT_W-1)-1`.
- R8: `irq_ack` is a one-cycle pulse that occurs exactly one cycle after `cpu_clk_en` rises, with `irq_ack_id` valid. The block is running again in the following cycle.
- R9: Outside stabilization, `wdt_cnt` decrements every 32 cycles when `wdt_rate_sel`=0 and every 512 cycles when `wdt_rate_sel`=1. This also holds after a wake-up.
- R10: While running, `wdt_irq` pulses for one cycle as `wdt_cnt` decrements from `2^(CNT_W-1)`, so pulses are `2^CNT_W` ticks apart. It is never raised during stabilization.
- R11: Asserting `rst_n` while stopped or stabilizing immediately forces the running state: clock enables on, `wdt_cnt` = 0, no `irq_ack`.
- R12: `stop_req` is ignored unless the block is running. A stop request during stabilization does not change the wake-up timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stop_req | input | 1 | Stop command strobe |
| ext_clk_sel | input | 1 | 1 = stable external clock input, 0 = on-chip oscillator |
| pll_sel | input | 1 | 1 = system clock taken from the PLL |
| pll_on | input | 1 | PLL operation enable bit |
| wake_div | input | 2 | Stabilization prescaler tap: 16 << wake_div |
| wdt_rate_sel | input | 1 | Normal watchdog tap: 0 = /32, 1 = /512 |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| irq_cond | input | N_IRQ | Per-source wake condition (used where COND_MASK is 1) |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| per_clk_en | output | 1 | Peripheral and system clock enable |
| cpu_clk_en | output | 1 | CPU and bus clock enable |
| irq_ack | output | 1 | Wake interrupt accept strobe |
| irq_ack_id | output | $clog2(N_IRQ) | Index of the waking interrupt |
| wdt_cnt | output | CNT_W | Shared watchdog/stabilization counter |
| wdt_irq | output | 1 | Watchdog midpoint pulse while running |

## Verification
The bench builds the block with `CNT_W`=6, so a stabilization wait lasts 32 counter ticks instead of 2048. This brings every `wake_div` tap, including divide by 128, into reach many times within the run, and lets the exact wake-up latency be checked for each tap. `N_IRQ`=8 with `COND_MASK`=0xF0 places gated and ungated sources side by side, so both the blocking rule and the lowest-index tie rule can be exercised. The default prescaler taps are kept, so the /32 and /512 watchdog rates and the `wdt_irq` spacing of 2048 cycles are measured directly.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2,
    ST_ACPT = 2'd3
  } swk_state_e;
endpackage

// File: rtl/swk_prescaler.sv
module swk_prescaler #(
  parameter int WAKE_BASE = 4,
  parameter int NORM_LO   = 5,
  parameter int NORM_HI   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] wake_div,
  input  logic       norm_sel,
  output logic       tick_wake,
  output logic       tick_norm
);
  localparam int PRE_W = (NORM_HI > WAKE_BASE + 3) ? NORM_HI : WAKE_BASE + 3;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [3:0]       wake_hit;
  logic             norm_lo_hit, norm_hi_hit;

  always_comb begin
    if (hold) pre_d = '0;
    else      pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar g = 0; g < 4; g++) begin : g_wake_tap
    assign wake_hit[g] = &pre_q[WAKE_BASE+g-1:0];
  end

  assign norm_lo_hit = &pre_q[NORM_LO-1:0];
  assign norm_hi_hit = &pre_q[NORM_HI-1:0];

  assign tick_wake = !hold && wake_hit[wake_div];
  assign tick_norm = !hold && (norm_sel ? norm_hi_hit : norm_lo_hit);
endmodule

// File: rtl/swk_wdt_cnt.sv
module swk_wdt_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             msb
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)     cnt_d = '1;
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign msb = cnt_q[CNT_W-1];
endmodule

// File: rtl/swk_wake_qual.sv
module swk_wake_qual #(
  parameter int               N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] COND_MASK = '0,
  parameter int               IDW       = 3
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_cond,
  output logic             wake_any,
  output logic [IDW-1:0]   wake_id
);
  logic [N_IRQ-1:0] qual;

  assign qual     = irq_req & irq_en & (~COND_MASK | irq_cond);
  assign wake_any = |qual;

  // lowest index wins when several qualify together
  always_comb begin
    wake_id = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (qual[i]) wake_id = IDW'(i);
    end
  end
endmodule

// File: rtl/swk_ctrl_fsm.sv
module swk_ctrl_fsm
  import swk_pkg::*;
#(
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_req,
  input  logic           wake_any,
  input  logic [IDW-1:0] wake_id,
  input  logic           fast_sel,
  input  logic           cnt_msb,
  input  logic           pll_on,
  output swk_state_e     state,
  output logic           skip,
  output logic           load,
  output logic           osc_en,
  output logic           pll_en,
  output logic           per_en,
  output logic           cpu_en,
  output logic           ack,
  output logic [IDW-1:0] ack_id
);
  swk_state_e     state_q, state_d;
  logic           skip_q, skip_d;
  logic [IDW-1:0] id_q, id_d;
  logic           stab_done;

  assign stab_done = skip_q || !cnt_msb;

  always_comb begin
    state_d = state_q;
    skip_d  = skip_q;
    id_d    = id_q;
    unique case (state_q)
      ST_RUN:  if (stop_req) state_d = ST_STOP;
      ST_STOP: begin
        if (wake_any) begin
          state_d = ST_STAB;
          skip_d  = fast_sel;
          id_d    = wake_id;
        end
      end
      ST_STAB: if (stab_done) state_d = ST_ACPT;
      ST_ACPT: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      skip_q  <= 1'b0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      id_q    <= id_d;
    end
  end

  assign state  = state_q;
  assign skip   = skip_q;
  assign load   = (state_q == ST_STOP) && wake_any && !fast_sel;
  assign osc_en = (state_q != ST_STOP);
  assign per_en = (state_q != ST_STOP);
  assign pll_en = pll_on && (state_q != ST_STOP);
  assign cpu_en = (state_q == ST_RUN) || (state_q == ST_ACPT) ||
                  ((state_q == ST_STAB) && stab_done);
  assign ack    = (state_q == ST_ACPT);
  assign ack_id = id_q;
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swk_pkg::*;
#(
  parameter int               N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] COND_MASK = 8'hF0,
  parameter int               CNT_W     = 12,
  parameter int               WAKE_BASE = 4,
  parameter int               NORM_LO   = 5,
  parameter int               NORM_HI   = 9,
  localparam int              IDW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             ext_clk_sel,
  input  logic             pll_sel,
  input  logic             pll_on,
  input  logic [1:0]       wake_div,
  input  logic             wdt_rate_sel,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_cond,
  output logic             osc_en,
  output logic             pll_en,
  output logic             per_clk_en,
  output logic             cpu_clk_en,
  output logic             irq_ack,
  output logic [IDW-1:0]   irq_ack_id,
  output logic [CNT_W-1:0] wdt_cnt,
  output logic             wdt_irq
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  swk_state_e     st;
  logic           skip, load, dec, cnt_msb;
  logic           tick_wake, tick_norm;
  logic           wake_any, fast_sel;
  logic [IDW-1:0] wake_id;

  assign fast_sel = ext_clk_sel && !pll_sel;

  swk_wake_qual #(
    .N_IRQ(N_IRQ), .COND_MASK(COND_MASK), .IDW(IDW)
  ) u_qual (
    .irq_req(irq_req), .irq_en(irq_en), .irq_cond(irq_cond),
    .wake_any(wake_any), .wake_id(wake_id)
  );

  swk_prescaler #(
    .WAKE_BASE(WAKE_BASE), .NORM_LO(NORM_LO), .NORM_HI(NORM_HI)
  ) u_pre (
    .clk(clk), .rst_n(rst_q_n), .hold(st == ST_STOP),
    .wake_div(wake_div), .norm_sel(wdt_rate_sel),
    .tick_wake(tick_wake), .tick_norm(tick_norm)
  );

  // wake tap only while a real stabilization wait is running
  assign dec = ((st == ST_STAB) && !skip) ? tick_wake : tick_norm;

  swk_wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .load(load), .dec(dec),
    .cnt(wdt_cnt), .msb(cnt_msb)
  );

  swk_ctrl_fsm #(.IDW(IDW)) u_fsm (
    .clk(clk), .rst_n(rst_q_n), .stop_req(stop_req),
    .wake_any(wake_any), .wake_id(wake_id), .fast_sel(fast_sel),
    .cnt_msb(cnt_msb), .pll_on(pll_on), .state(st), .skip(skip),
    .load(load), .osc_en(osc_en), .pll_en(pll_en), .per_en(per_clk_en),
    .cpu_en(cpu_clk_en), .ack(irq_ack), .ack_id(irq_ack_id)
  );

  assign wdt_irq = (st == ST_RUN) && tick_norm && (wdt_cnt == MID);
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             pll_en,
  input logic             per_clk_en,
  input logic             cpu_clk_en,
  input logic             irq_ack,
  input logic             wdt_irq,
  input logic [CNT_W-1:0] wdt_cnt
);
  // R2
  stop_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!per_clk_en && !cpu_clk_en && !pll_en));

  // R5
  osc_per_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> per_clk_en);

  // R7
  slow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_en) && !cpu_clk_en) |-> (wdt_cnt == {CNT_W{1'b1}}));

  // R7
  msb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(osc_en)) |-> !wdt_cnt[CNT_W-1]);

  // R8
  ack_after_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (cpu_clk_en && $past(cpu_clk_en)));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_ack && cpu_clk_en));

  // R10
  wdt_irq_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> (cpu_clk_en && $past(cpu_clk_en) && !irq_ack));
endmodule

bind stop_wake_seq swk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .osc_en(osc_en), .pll_en(pll_en),
  .per_clk_en(per_clk_en), .cpu_clk_en(cpu_clk_en), .irq_ack(irq_ack),
  .wdt_irq(wdt_irq), .wdt_cnt(wdt_cnt)
);

// File: tb/sim_stop_wake_seq.sv
`timescale 1ns/1ps
module sim_stop_wake_seq;
  localparam int N  = 8;
  localparam int CW = 6;
  localparam int MIDV = 1 << (CW - 1);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         stop_req, ext_clk_sel, pll_sel, pll_on, wdt_rate_sel;
  logic [1:0]   wake_div;
  logic [N-1:0] irq_req, irq_en, irq_cond;
  logic         osc_en, pll_en, per_clk_en, cpu_clk_en, irq_ack, wdt_irq;
  logic [2:0]   irq_ack_id;
  logic [CW-1:0] wdt_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  stop_wake_seq #(.N_IRQ(N), .COND_MASK(8'hF0), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .ext_clk_sel(ext_clk_sel),
    .pll_sel(pll_sel), .pll_on(pll_on), .wake_div(wake_div),
    .wdt_rate_sel(wdt_rate_sel), .irq_req(irq_req), .irq_en(irq_en),
    .irq_cond(irq_cond), .osc_en(osc_en), .pll_en(pll_en),
    .per_clk_en(per_clk_en), .cpu_clk_en(cpu_clk_en), .irq_ack(irq_ack),
    .irq_ack_id(irq_ack_id), .wdt_cnt(wdt_cnt), .wdt_irq(wdt_irq)
  );

  function automatic int exp_wait(bit ext, bit psel, int div);
    if (ext && !psel) return 0;
    return MIDV << (4 + div);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic enter_stop(string req);
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    chk(req, {osc_en, pll_en, per_clk_en, cpu_clk_en}, 0);
  endtask

  // configure, stop, wake by one source and check the whole sequence
  task automatic wake_seq(int src, bit ext, bit psel, int div, bit pon,
                          bit poke, string req);
    int n, ew;
    bit saw_wdt;
    @(negedge clk);
    ext_clk_sel = ext; pll_sel = psel; wake_div = 2'(div); pll_on = pon;
    enter_stop("R2 stop gates");
    @(negedge clk) irq_req[src] = 1'b1;
    @(posedge clk); #1;
    chk("R5 osc/per on wake", {osc_en, per_clk_en}, 3);
    chk("R5 pll follows pll_on", pll_en, pon);
    n = 0; saw_wdt = 0;
    while (!cpu_clk_en && n < 20000) begin
      @(posedge clk); #1;
      n++;
      if (wdt_irq) saw_wdt = 1;
      if (poke && n == 3) stop_req = 1'b1;
      if (poke && n == 4) stop_req = 1'b0;
    end
    ew = exp_wait(ext, psel, div);
    chk({req, " wake latency"}, n, ew);
    if (ew != 0) chk("R7 counter at release", wdt_cnt, MIDV - 1);
    chk("R10 no wdt_irq while stabilizing", saw_wdt, 0);
    chk("R8 no ack with cpu rise", irq_ack, 0);
    @(posedge clk); #1;
    chk("R8 ack pulse", irq_ack, 1);
    chk("R4 ack id", irq_ack_id, src);
    @(posedge clk); #1;
    chk("R8 ack single", {irq_ack, cpu_clk_en, osc_en}, 3);
    @(negedge clk) irq_req = '0;
  endtask

  task automatic rate_chk(bit sel, string req);
    int n;
    logic [CW-1:0] prev;
    @(negedge clk) wdt_rate_sel = sel;
    @(posedge clk); #1;
    prev = wdt_cnt;
    n = 0;
    while (wdt_cnt == prev && n < 2000) begin @(posedge clk); #1; n++; end
    prev = wdt_cnt; n = 0;
    while (wdt_cnt == prev && n < 2000) begin @(posedge clk); #1; n++; end
    chk(req, n, sel ? 512 : 32);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int t0, t1, n;
    void'($urandom(32'd7401));
    rst_n = 1'b0; stop_req = 0; ext_clk_sel = 0; pll_sel = 0; pll_on = 1;
    wake_div = 0; wdt_rate_sel = 0; irq_req = '0; irq_en = '1; irq_cond = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 enables", {osc_en, per_clk_en, cpu_clk_en, pll_en}, 15);
    chk("R1 counter", wdt_cnt, 0);
    chk("R1 ack", irq_ack, 0);

    // R9 normal rates
    rate_chk(1'b0, "R9 rate /32");
    rate_chk(1'b1, "R9 rate /512");
    rate_chk(1'b0, "R9 rate back /32");

    // R10 midpoint pulse spacing
    n = 0;
    while (!wdt_irq && n < 5000) begin @(posedge clk); #1; n++; end
    chk("R10 cnt at pulse", wdt_cnt, MIDV);
    t0 = n; n++;
    @(posedge clk); #1;
    chk("R10 single pulse", wdt_irq, 0);
    while (!wdt_irq && n < 10000) begin @(posedge clk); #1; n++; end
    t1 = n;
    chk("R10 pulse spacing", t1 - t0, 32 << CW);

    // R7 each wake tap, R6 fast path, R12 poke
    for (int d = 0; d < 4; d++) wake_seq(1, 0, 0, d, 1, 0, "R7 osc tap");
    wake_seq(2, 1, 1, 1, 1, 0, "R7 pll path");
    wake_seq(0, 1, 0, 3, 0, 0, "R6 fast path");
    wake_seq(3, 0, 0, 0, 0, 1, "R12 stop ignored");
    rate_chk(1'b1, "R9 rate after wake");
    @(negedge clk) wdt_rate_sel = 0;

    // R3 gated and disabled sources are ignored
    @(negedge clk) ext_clk_sel = 0; pll_sel = 0; wake_div = 0;
    enter_stop("R2 stop gates");
    irq_cond[5] = 0; irq_en[1] = 0;
    @(negedge clk) irq_req[5] = 1; irq_req[1] = 1;
    repeat (40) @(posedge clk); #1;
    chk("R3 blocked stays stopped", {osc_en, cpu_clk_en}, 0);
    n = 0;
    repeat (20) begin @(posedge clk); #1; if (wdt_cnt != '1 && wdt_cnt != 0) n = n; end
    @(negedge clk) irq_cond[5] = 1;
    @(posedge clk); #1;
    chk("R3 condition met wakes", osc_en, 1);
    while (!irq_ack && n < 20000) begin @(posedge clk); #1; n++; end
    chk("R4 gated source id", irq_ack_id, 5);
    @(negedge clk) irq_req = '0; irq_en = '1;

    // R4 simultaneous -> lowest index
    enter_stop("R2 stop gates");
    @(negedge clk) irq_req[6] = 1; irq_req[3] = 1;
    n = 0;
    while (!irq_ack && n < 20000) begin @(posedge clk); #1; n++; end
    chk("R4 tie lowest", irq_ack_id, 3);
    @(negedge clk) irq_req = '0;

    // R4 first to occur keeps its id
    enter_stop("R2 stop gates");
    @(negedge clk) irq_req[6] = 1;
    @(negedge clk) irq_req[0] = 1;
    n = 0;
    while (!irq_ack && n < 20000) begin @(posedge clk); #1; n++; end
    chk("R4 first wins", irq_ack_id, 6);
    @(negedge clk) irq_req = '0;

    // R2 counter frozen while stopped
    enter_stop("R2 stop gates");
    t0 = wdt_cnt;
    repeat (600) @(posedge clk); #1;
    chk("R2 counter frozen", wdt_cnt, t0);

    // R11 reset while stopped
    @(negedge clk) rst_n = 0;
    #1;
    chk("R11 enables on", {osc_en, per_clk_en, cpu_clk_en}, 7);
    chk("R11 counter clear", wdt_cnt, 0);
    chk("R11 no ack", irq_ack, 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // random configurations
    for (int k = 0; k < 8; k++) begin
      wake_seq($urandom_range(0, N - 1), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), $urandom_range(0, 3),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               "R7 random wake");
    end

    finish_run();
  end
endmodule